// File: doc/BRIEF.md
# Register-Operand Decode and Execute Stage

This block executes the register-only slice of a 32-bit load/store instruction set with three fixed instruction layouts. One instruction word arrives per accepted transfer on a valid/ready input. The block splits it into fields and reads two source registers from a 32-entry, 32-bit register file. It then computes the arithmetic, logic, compare, shift or constant result and writes it to the destination register on the same clock edge that accepts the instruction. Each committed write is also reported on a registered write-back port one cycle later.

Loads and stores leave as a memory request. The request carries a byte address, formed from the base register plus the sign-extended 16-bit offset, together with the store data. The request is valid while the instruction is offered and completes when `mem_ready` is high. The block then waits for the load word, which returns on `ld_valid`/`ld_data` and is written to the load's target register. Back-pressure works in two ways. A memory instruction is not taken until its request is accepted, and no instruction is taken while a load is outstanding. The upstream side must hold `in_instr` steady while `in_valid` is high and `in_ready` is low. Fetch, sequencing, the memory itself, exceptions and multiply sit outside the block.

Top module: `rx_datapath`

## Requirements
- R1: Register-format words (bits 31:26 = 0) take sources from bits 25:21 (first) and 20:16 (second) and write bits 15:11. Function code (bits 5:0) 32 adds and 34 subtracts, both wrapping modulo 2^32.
- R2: Function code 36 writes the bitwise AND of the two sources, and 37 writes the bitwise OR.
- R3: Function code 42 writes 1 when the first source is less than the second as signed two's complement numbers, and 0 otherwise.
- R4: Function code 0 shifts the second source left and code 2 shifts it right logically, by the amount in bits 10:6.
- R5: Immediate-format words write the register in bits 20:16. Opcode 8 adds the sign-extended imm[15:0] and opcode 10 is a signed less-than against it. Opcode 12 ANDs and opcode 13 ORs with the zero-extended immediate.
- R6: Opcode 15 writes imm[15:0] into bits 31:16 and clears bits 15:0, so that a following opcode 13 completes a 32-bit constant.
- R7: Register 0 always reads as zero, and a write to it changes nothing and produces no write-back pulse.
- R8: Opcode 35 issues a read request (`mem_we`=0) at base plus sign-extended offset. The word on `ld_valid` is then written to register bits 20:16, and `ld_valid` has no effect when no load is outstanding.
- R9: Opcode 43 issues a write request (`mem_we`=1) at base plus sign-extended offset, with the register in bits 20:16 as `mem_wdata`, and writes no register.
- R10: Any other opcode or register-format function code raises `bad_instr` for one cycle and writes no register.
- R11: `in_ready` is low while a memory instruction's request is not accepted and throughout an outstanding load. `mem_valid` stays high with a stable address while the request waits.
- R12: During and after reset, all registers read zero, `wb_valid` and `bad_instr` are low, and a non-memory instruction sees `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction taken this cycle when valid |
| in_instr | input | 32 | Instruction word |
| mem_valid | output | 1 | Memory request offered |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Store data |
| ld_valid | input | 1 | Load word present |
| ld_data | input | 32 | Load word |
| wb_valid | output | 1 | A register was written on the last edge |
| wb_idx | output | 5 | Index of the register written |
| wb_data | output | 32 | Value written |
| bad_instr | output | 1 | Last accepted word was unrecognised |

## Verification
The memory request fields and `in_ready` are combinational, so they are due in the same cycle as the offered word. The bench samples them one time unit after it drives the inputs. The write-back port and `bad_instr` are due one cycle after the accepting edge, and for a load one cycle after the edge on which `ld_valid` is seen. A behavioural model holds its expected write-back values in step with each rising edge, and the bench compares them at every falling edge. Stalled requests are held for several cycles, and the bench checks `in_ready` and the request on each of those cycles.

// File: rtl/rx_pkg.sv
package rx_pkg;
  localparam logic [5:0] OPC_REG  = 6'd0;
  localparam logic [5:0] OPC_ADDI = 6'd8;
  localparam logic [5:0] OPC_SLTI = 6'd10;
  localparam logic [5:0] OPC_ANDI = 6'd12;
  localparam logic [5:0] OPC_ORI  = 6'd13;
  localparam logic [5:0] OPC_LUI  = 6'd15;
  localparam logic [5:0] OPC_LW   = 6'd35;
  localparam logic [5:0] OPC_SW   = 6'd43;

  localparam logic [5:0] FN_SLL = 6'd0;
  localparam logic [5:0] FN_SRL = 6'd2;
  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_SLL, ALU_SRL, ALU_HI
  } alu_op_e;

  typedef enum logic {ST_RUN, ST_WAIT} exec_st_e;

  typedef struct packed {
    alu_op_e    op;
    logic       b_imm;
    logic       wr_en;
    logic [4:0] dst;
    logic       is_load;
    logic       is_store;
    logic       bad;
  } ctrl_t;
endpackage

// File: rtl/rx_decode.sv
module rx_decode
  import rx_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [31:0]  instr,
  output ctrl_t        ctrl,
  output logic [4:0]   rs_idx,
  output logic [4:0]   rt_idx,
  output logic [4:0]   shamt,
  output logic [W-1:0] imm
);
  logic [5:0] opc;
  logic [5:0] fn;
  logic [4:0] rd_idx;
  logic       zext;

  assign opc    = instr[31:26];
  assign rs_idx = instr[25:21];
  assign rt_idx = instr[20:16];
  assign rd_idx = instr[15:11];
  assign shamt  = instr[10:6];
  assign fn     = instr[5:0];

  // logic-type immediates are zero-extended, arithmetic and address ones sign-extended
  assign zext = (opc == OPC_ANDI) || (opc == OPC_ORI) || (opc == OPC_LUI);
  assign imm  = zext ? {{(W-16){1'b0}}, instr[15:0]}
                     : {{(W-16){instr[15]}}, instr[15:0]};

  always_comb begin
    ctrl = '{op: ALU_ADD, b_imm: 1'b0, wr_en: 1'b0, dst: rt_idx,
             is_load: 1'b0, is_store: 1'b0, bad: 1'b0};
    case (opc)
      OPC_REG: begin
        ctrl.dst   = rd_idx;
        ctrl.wr_en = 1'b1;
        case (fn)
          FN_ADD: ctrl.op = ALU_ADD;
          FN_SUB: ctrl.op = ALU_SUB;
          FN_AND: ctrl.op = ALU_AND;
          FN_OR:  ctrl.op = ALU_OR;
          FN_SLT: ctrl.op = ALU_SLT;
          FN_SLL: ctrl.op = ALU_SLL;
          FN_SRL: ctrl.op = ALU_SRL;
          default: begin
            ctrl.wr_en = 1'b0;
            ctrl.bad   = 1'b1;
          end
        endcase
      end
      OPC_ADDI: begin ctrl.b_imm = 1'b1; ctrl.wr_en = 1'b1; end
      OPC_SLTI: begin ctrl.op = ALU_SLT; ctrl.b_imm = 1'b1; ctrl.wr_en = 1'b1; end
      OPC_ANDI: begin ctrl.op = ALU_AND; ctrl.b_imm = 1'b1; ctrl.wr_en = 1'b1; end
      OPC_ORI:  begin ctrl.op = ALU_OR;  ctrl.b_imm = 1'b1; ctrl.wr_en = 1'b1; end
      OPC_LUI:  begin ctrl.op = ALU_HI;  ctrl.b_imm = 1'b1; ctrl.wr_en = 1'b1; end
      OPC_LW:   begin ctrl.b_imm = 1'b1; ctrl.is_load  = 1'b1; end
      OPC_SW:   begin ctrl.b_imm = 1'b1; ctrl.is_store = 1'b1; end
      default:  ctrl.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/rx_alu.sv
module rx_alu
  import rx_pkg::*;
#(
  parameter int W    = 32,
  parameter int SH_W = $clog2(W)
) (
  input  alu_op_e         op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [SH_W-1:0] sh,
  output logic [W-1:0]    y
);
  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_SLL: y = b << sh;
      ALU_SRL: y = b >> sh;
      ALU_HI:  y = b << (W/2);
    endcase
  end
endmodule

// File: rtl/rx_regfile.sv
module rx_regfile #(
  parameter int N  = 32,
  parameter int W  = 32,
  parameter int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [W-1:0]  da,
  output logic [W-1:0]  db,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] cells [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) cells[i] <= '0;
    end else if (we && (wa != '0)) begin
      cells[wa] <= wd;
    end
  end

  assign da = (ra == '0) ? '0 : cells[ra];
  assign db = (rb == '0) ? '0 : cells[rb];
endmodule

// File: rtl/rx_datapath.sv
module rx_datapath
  import rx_pkg::*;
#(
  parameter int W    = 32,
  parameter int REGS = 32,
  parameter int AW   = $clog2(REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [31:0]   in_instr,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [W-1:0]  mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic          ld_valid,
  input  logic [W-1:0]  ld_data,
  output logic          wb_valid,
  output logic [AW-1:0] wb_idx,
  output logic [W-1:0]  wb_data,
  output logic          bad_instr
);
  localparam int SH_W = $clog2(W);

  ctrl_t        ctrl;
  logic [4:0]   rs_idx, rt_idx, shamt;
  logic [W-1:0] imm, rs_data, rt_data, alu_b, alu_y;
  exec_st_e     st;
  logic [AW-1:0] ld_dst;
  logic         mem_op, acc, rf_we, waiting;
  logic [AW-1:0] rf_wa;
  logic [W-1:0] rf_wd;

  rx_decode #(.W(W)) u_dec (
    .instr(in_instr), .ctrl(ctrl), .rs_idx(rs_idx), .rt_idx(rt_idx),
    .shamt(shamt), .imm(imm)
  );

  rx_regfile #(.N(REGS), .W(W), .AW(AW)) u_rf (
    .clk(clk), .rst_n(rst_n), .ra(rs_idx), .rb(rt_idx), .da(rs_data),
    .db(rt_data), .we(rf_we), .wa(rf_wa), .wd(rf_wd)
  );

  assign alu_b = ctrl.b_imm ? imm : rt_data;

  rx_alu #(.W(W), .SH_W(SH_W)) u_alu (
    .op(ctrl.op), .a(rs_data), .b(alu_b), .sh(shamt[SH_W-1:0]), .y(alu_y)
  );

  assign waiting   = (st == ST_WAIT);
  assign mem_op    = ctrl.is_load || ctrl.is_store;
  assign in_ready  = !waiting && (!mem_op || mem_ready);
  assign acc       = in_valid && in_ready;
  assign mem_valid = in_valid && !waiting && mem_op;
  assign mem_we    = ctrl.is_store;
  assign mem_addr  = alu_y;
  assign mem_wdata = rt_data;

  // one write port: the load return owns it while waiting, the stage otherwise
  assign rf_we = waiting ? ld_valid : (acc && ctrl.wr_en);
  assign rf_wa = waiting ? ld_dst : ctrl.dst;
  assign rf_wd = waiting ? ld_data : alu_y;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_RUN;
      ld_dst <= '0;
    end else if (waiting) begin
      if (ld_valid) st <= ST_RUN;
    end else if (acc && ctrl.is_load) begin
      st     <= ST_WAIT;
      ld_dst <= rt_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid  <= 1'b0;
      wb_idx    <= '0;
      wb_data   <= '0;
      bad_instr <= 1'b0;
    end else begin
      wb_valid  <= rf_we && (rf_wa != '0);
      wb_idx    <= rf_wa;
      wb_data   <= rf_wd;
      bad_instr <= acc && ctrl.bad;
    end
  end

  a_r7_no_zero_wb: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_idx != '0));

  a_r10_bad_blocks_wb: assert property (@(posedge clk) disable iff (!rst_n)
    bad_instr |-> !wb_valid);

  a_r11_wait_holds_input: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !in_ready);

  a_r11_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

  a_r6_hi_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ctrl.wr_en && (ctrl.op == ALU_HI) && (ctrl.dst != '0))
      |=> (wb_valid && (wb_data[W/2-1:0] == '0)));

  a_r8_load_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && ld_valid) |=> !waiting);
endmodule

// File: tb/sim_rx_datapath.sv
module sim_rx_datapath;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic        mem_valid, mem_we;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata;
  logic        ld_valid = 1'b0;
  logic [31:0] ld_data = '0;
  logic        wb_valid, bad_instr;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_datapath u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .ld_valid(ld_valid), .ld_data(ld_data), .wb_valid(wb_valid),
    .wb_idx(wb_idx), .wb_data(wb_data), .bad_instr(bad_instr)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit chk_on = 1'b0;

  logic [31:0] m [32];

  bit          pend_v = 0, pend_bad = 0, exp_v = 0, exp_bad = 0;
  logic [4:0]  pend_idx = '0, exp_idx = '0;
  logic [31:0] pend_data = '0, exp_data = '0;
  string       pend_tag = "R12", exp_tag = "R12";

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) begin
      checks++;
      if (wb_valid !== exp_v || bad_instr !== exp_bad ||
          (exp_v && (wb_idx !== exp_idx || wb_data !== exp_data))) begin
        fails++;
        $display("FAIL %s actual v=%b bad=%b idx=%0d data=%h expected v=%b bad=%b idx=%0d data=%h",
                 exp_tag, wb_valid, bad_instr, wb_idx, wb_data,
                 exp_v, exp_bad, exp_idx, exp_data);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    exp_v = pend_v; exp_bad = pend_bad; exp_idx = pend_idx;
    exp_data = pend_data; exp_tag = pend_tag;
    pend_v = 0; pend_bad = 0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] r_ins(input int s, input int t, input int d,
                                        input int sh, input int fn);
    logic [31:0] w;
    w = {6'd0, s[4:0], t[4:0], d[4:0], sh[4:0], fn[5:0]};
    return w;
  endfunction

  function automatic logic [31:0] i_ins(input int op, input int s, input int t,
                                        input int im);
    logic [31:0] w;
    w = {op[5:0], s[4:0], t[4:0], im[15:0]};
    return w;
  endfunction

  function automatic void model(input logic [31:0] i, output bit legal,
                                output bit wr, output bit ld, output bit st,
                                output logic [4:0] d, output logic [31:0] v,
                                output logic [31:0] addr);
    logic [31:0] a, b, sx, zx;
    a  = m[i[25:21]];
    b  = m[i[20:16]];
    sx = {{16{i[15]}}, i[15:0]};
    zx = {16'h0, i[15:0]};
    legal = 1; wr = 1; ld = 0; st = 0; d = i[20:16]; v = '0; addr = a + sx;
    case (i[31:26])
      6'd0: begin
        d = i[15:11];
        case (i[5:0])
          6'd32: v = a + b;
          6'd34: v = a - b;
          6'd36: v = a & b;
          6'd37: v = a | b;
          6'd42: v = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          6'd0:  v = b << i[10:6];
          6'd2:  v = b >> i[10:6];
          default: begin legal = 0; wr = 0; end
        endcase
      end
      6'd8:  v = a + sx;
      6'd10: v = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0;
      6'd12: v = a & zx;
      6'd13: v = a | zx;
      6'd15: v = {i[15:0], 16'h0};
      6'd35: begin wr = 0; ld = 1; end
      6'd43: begin wr = 0; st = 1; end
      default: begin legal = 0; wr = 0; end
    endcase
  endfunction

  task automatic run(input logic [31:0] ins, input string tag,
                     input int stall, input logic [31:0] ldw);
    bit legal, wr, ld, st;
    logic [4:0]  d;
    logic [31:0] v, addr, wd;
    model(ins, legal, wr, ld, st, d, v, addr);
    wd = m[ins[20:16]];
    in_valid = 1; in_instr = ins; mem_ready = (stall == 0);
    #1;
    if (ld || st) begin
      chk(mem_valid === 1'b1, tag, {31'd0, mem_valid}, 32'd1);
      chk(mem_addr === addr, tag, mem_addr, addr);
      chk(mem_we === st, tag, {31'd0, mem_we}, {31'd0, st});
      if (st) chk(mem_wdata === wd, tag, mem_wdata, wd);
      chk(in_ready === (stall == 0), "R11", {31'd0, in_ready}, {31'd0, stall == 0});
    end else begin
      chk(mem_valid === 1'b0, tag, {31'd0, mem_valid}, 32'd0);
      chk(in_ready === 1'b1, "R11", {31'd0, in_ready}, 32'd1);
    end
    for (int k = 0; k < stall; k++) begin
      tick();
      if (k == stall - 1) mem_ready = 1;
      #1;
      chk(mem_valid === 1'b1 && mem_addr === addr, "R11", mem_addr, addr);
      chk(in_ready === (k == stall - 1), "R11", {31'd0, in_ready}, {31'd0, k == stall - 1});
    end
    pend_tag = tag;
    if (!legal) pend_bad = 1;
    else if (wr && d != 0) begin pend_v = 1; pend_idx = d; pend_data = v; end
    tick();
    if (legal && wr && d != 0) m[d] = v;
    in_valid = 0; mem_ready = 0;
    if (ld) begin
      #1;
      chk(in_ready === 1'b0, "R11", {31'd0, in_ready}, 32'd0);
      tick();
      #1;
      chk(in_ready === 1'b0, "R11", {31'd0, in_ready}, 32'd0);
      ld_valid = 1; ld_data = ldw; pend_tag = tag;
      if (d != 0) begin pend_v = 1; pend_idx = d; pend_data = ldw; end
      tick();
      ld_valid = 0;
      if (d != 0) m[d] = ldw;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R11 watchdog expired actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    for (int r = 0; r < 32; r++) m[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R12: reset state seen at the ports
    chk(in_ready === 1'b1, "R12", {31'd0, in_ready}, 32'd1);
    chk(wb_valid === 1'b0, "R12", {31'd0, wb_valid}, 32'd0);
    chk(bad_instr === 1'b0, "R12", {31'd0, bad_instr}, 32'd0);
    chk_on = 1;
    tick();
    run(r_ins(1, 2, 3, 0, 32), "R12", 0, '0);          // zero regs sum to 0

    run(i_ins(13, 0, 1, 16'h1234), "R5", 0, '0);       // ori
    run(i_ins(8, 0, 2, 16'hFFFB), "R5", 0, '0);        // addi -5
    run(i_ins(12, 2, 3, 16'hFFF0), "R5", 0, '0);       // andi zero-extended
    run(i_ins(10, 2, 13, 16'hFFFC), "R5", 0, '0);      // slti -5 < -4
    run(i_ins(10, 1, 22, 16'hFFFC), "R5", 0, '0);      // slti positive vs -4
    run(i_ins(15, 0, 4, 16'hDEAD), "R6", 0, '0);       // lui
    run(i_ins(13, 4, 4, 16'hBEEF), "R6", 0, '0);       // ori low half
    run(r_ins(1, 2, 5, 0, 32), "R1", 0, '0);
    run(r_ins(1, 2, 6, 0, 34), "R1", 0, '0);
    run(r_ins(4, 4, 7, 0, 32), "R1", 0, '0);           // wraps
    run(r_ins(2, 1, 23, 0, 34), "R1", 0, '0);          // negative result
    run(r_ins(4, 1, 8, 0, 36), "R2", 0, '0);
    run(r_ins(4, 1, 9, 0, 37), "R2", 0, '0);
    run(r_ins(2, 1, 10, 0, 42), "R3", 0, '0);          // neg < pos -> 1
    run(r_ins(1, 2, 11, 0, 42), "R3", 0, '0);          // pos < neg -> 0
    run(r_ins(4, 4, 12, 0, 42), "R3", 0, '0);          // equal -> 0
    run(r_ins(0, 4, 14, 4, 0), "R4", 0, '0);
    run(r_ins(0, 4, 15, 31, 2), "R4", 0, '0);          // logical, no sign fill
    run(r_ins(0, 2, 24, 0, 2), "R4", 0, '0);           // zero shift
    run(r_ins(1, 1, 0, 0, 32), "R7", 0, '0);           // write to r0 dropped
    run(r_ins(0, 0, 16, 0, 37), "R7", 0, '0);          // r0 still reads 0
    run(i_ins(43, 1, 4, 32), "R9", 2, '0);             // store, stalled twice
    run(i_ins(43, 2, 9, 16'hFFFC), "R9", 0, '0);       // negative offset
    run(i_ins(35, 1, 17, 16'hFFF8), "R8", 1, 32'hCAFEF00D);
    run(r_ins(17, 0, 18, 0, 32), "R8", 0, '0);         // loaded value readable
    run(i_ins(35, 0, 0, 8), "R7", 0, 32'h12345678);    // load to r0 dropped
    ld_valid = 1; ld_data = 32'hFFFFFFFF;              // stray return, no load open
    tick();
    ld_valid = 0;
    run(r_ins(17, 0, 21, 0, 37), "R8", 0, '0);         // r17 unchanged
    run(i_ins(63, 1, 1, 5), "R10", 0, '0);             // unknown opcode
    run(r_ins(2, 2, 1, 0, 1), "R10", 0, '0);           // unknown function code
    run(r_ins(1, 0, 20, 0, 37), "R10", 0, '0);         // r1 kept its value
    in_instr = r_ins(2, 2, 1, 0, 32);                  // not offered
    tick();
    tick();
    run(r_ins(1, 0, 25, 0, 32), "R11", 0, '0);         // r1 still intact
    tick();
    finish_run();
  end
endmodule